// File: doc/BRIEF.md
# Clocked Serial Transfer Engine

This block moves one byte at a time over a three-wire synchronous serial link: a serial clock, a data output and a data input. Each transfer sends eight bits and takes in eight bits, most significant bit first. A control byte sets three things. The first is where the serial clock comes from. The second is the level at which the clock rests. The third is whether data lead the first clock edge or follow it.

In master mode the engine makes the serial clock itself by dividing the system clock by a power of two from 2 to 128. In slave mode it follows a clock that an external device drives. It passes that clock through a two-flop synchroniser and then looks for edges.

Software writes the control byte while the engine is disabled, sets the enable input, and then writes a transmit byte to start a transfer. When the transfer ends, the received byte appears on the receive port together with a one-cycle done pulse.

Top module: `sio_engine`

## Requirements
- R1: After reset the control byte is 0x00. This means master mode, clock-select code 0 (divide by 2), polarity 0, phase 0, and timing type 1. After reset, rx_done is low, sdo is low, sck_o is high and sck_oe is low.
- R2: Clock-select codes 0 to 6 give a master serial clock whose half period is 2^code system cycles. The done pulse is first visible exactly 16 x 2^code cycles after the clock edge that accepts the transmit write.
- R3: Clock-select code 7 selects slave mode. In slave mode sck_oe is low and bits move on sck_i. In master mode with the engine enabled, sck_oe is high.
- R4: Control bit 4 is the polarity bit. When it is 0 the serial clock rests high, and when it is 1 the clock rests low.
- R5: Control bit 3 is the phase bit. With phase 0, sdo changes on the leading edge (the edge that leaves the rest level) and sdi is sampled on the trailing edge. With phase 1, the first bit is on sdo half a period before the first edge, sdi is sampled on the leading edge, and sdo changes on the trailing edge. The peer device must receive the correct byte in all four polarity/phase combinations, and so must the engine.
- R6: Bits are sent and received most significant bit first, eight per transfer.
- R7: A control write is ignored while enable is high. The clock rest level and the divide ratio then stay as they were.
- R8: A transmit write starts a transfer only while the engine is enabled and idle. A write while the engine is disabled, or during a transfer, has no effect.
- R9: At the end of a transfer, rx_done is high for exactly one cycle and rx_data holds the eight bits received.
- R10: While enable is low, sdo is held low and sck_o sits at the rest level set by the polarity bit.
- R11: In slave mode, sdo changes on the third system clock edge after sck_i changes (two synchroniser stages plus one register), and never sooner.
- R12: A transmit write made in the same cycle as rx_done is accepted. The next transfer then starts immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: [4] polarity, [3] phase, [2:0] clock select, [7:5] reserved |
| enable | input | 1 | Engine enable; locks the control byte while high |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_data | input | DATA_W | Byte to send |
| rx_data | output | DATA_W | Last byte received |
| rx_done | output | 1 | One-cycle pulse at transfer end |
| sck_i | input | 1 | Serial clock from the external device (slave mode) |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | High when sck_o should drive the clock pin |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The completion of one transfer and the start of the next can happen in the same cycle. The done pulse clears the busy state on the same edge that a new transmit write is sampled. The bench waits for rx_done, raises tx_we in that same cycle, and expects the second byte to be accepted with no idle clock periods in between. It judges this from the second transfer's done latency, which must be exactly 16 x 2^code cycles, and from both bytes arriving intact at the peer and at rx_data. A transmit write that arrives during a transfer, and a control write that arrives while enabled, are also placed mid-activity. The bench then checks that the running transfer's data and timing are unchanged.

// File: rtl/sio_pkg.sv
// Shared definitions for the serial transfer engine.
// Assumes a control byte with polarity at bit 4, phase at bit 3 and
// the clock-select code at bits 2:0.
package sio_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_SLAVE = '1;

    typedef struct packed {
        logic             pol;
        logic             pha;
        logic [SEL_W-1:0] sel;
    } sio_ctl_t;
endpackage

// File: rtl/sio_ctl_reg.sv
// Control register. Stores polarity, phase and clock select.
// Assumes the write is refused whenever lock (the engine enable) is high.
// Bits 7:5 of the written byte are reserved and are not stored.
module sio_ctl_reg
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       lock,
    output sio_ctl_t   ctl_q
);
    logic unused_rsvd;
    assign unused_rsvd = ^wdata[7:5];

    // Capture an unlocked write; otherwise hold the current value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (we && !lock)
            ctl_q <= sio_ctl_t'(wdata[4:0]);
    end

    // R7: a write while locked leaves the register untouched
    assert_ctl_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lock) |=> $stable(ctl_q));
endmodule

// File: rtl/sio_clkgen.sv
// Serial clock edge source. In master mode it divides clk so that
// the serial clock toggles every 2^sel cycles while run is high. In
// slave mode it synchronises sck_i through two flops and reports its
// edges. Edges are classed as leading (leaving the rest level) or
// trailing. sdi is delayed by the same amount in slave mode so that
// it stays aligned with the clock.
// Assumes sel is stable while run is high, and that the external
// clock is no faster than a quarter of clk.
module sio_clkgen
    import sio_pkg::*;
#(
    parameter int DIV_W = (1 << SEL_W) - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             slave,
    input  logic             pol,
    input  logic [SEL_W-1:0] sel,
    input  logic             sck_i,
    input  logic             sdi_i,
    output logic             ev_lead,
    output logic             ev_trail,
    output logic             sck_lvl,
    output logic             sdi_smp
);
    logic             idle_lvl;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] lim;
    logic             m_tick;
    logic [2:0]       s_sync;
    logic [1:0]       sdi_d;
    logic             s_edge;

    assign idle_lvl = ~pol;
    assign lim      = DIV_W'((32'd1 << sel) - 32'd1);
    assign m_tick   = run && !slave && (div_cnt == lim);
    assign s_edge   = s_sync[1] != s_sync[2];

    // Master divider and serial clock level, parked at rest when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sck_lvl <= 1'b1;
        end else if (!run || slave) begin
            div_cnt <= '0;
            sck_lvl <= idle_lvl;
        end else if (m_tick) begin
            div_cnt <= '0;
            sck_lvl <= ~sck_lvl;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Two-flop synchroniser plus history flop for the external clock and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_sync <= {3{1'b1}};
            sdi_d  <= '0;
        end else begin
            s_sync <= {s_sync[1:0], sck_i};
            sdi_d  <= {sdi_d[0], sdi_i};
        end
    end

    // Classify the current edge from whichever source is active.
    always_comb begin
        if (slave) begin
            ev_lead  = run && s_edge && (s_sync[2] == idle_lvl);
            ev_trail = run && s_edge && (s_sync[2] != idle_lvl);
            sdi_smp  = sdi_d[1];
        end else begin
            ev_lead  = m_tick && (sck_lvl == idle_lvl);
            ev_trail = m_tick && (sck_lvl != idle_lvl);
            sdi_smp  = sdi_i;
        end
    end

    // R2: with a divider above 2, master ticks never come back to back
    assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tick && sel != '0) |=> !m_tick);
    // R4: an idle master clock returns to the rest level on the next edge
    assert_rest_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !slave) |=> (sck_lvl == ~$past(pol)));
endmodule

// File: rtl/sio_shifter.sv
// Shift engine. Loads the transmit byte on an accepted write and
// counts 2*DATA_W serial clock edges. Depending on the phase bit it
// samples sdi on one edge kind and updates sdo on the other. It
// latches the received byte and pulses done after the final edge.
// Assumes edge strobes last one clk cycle and that pha is stable
// during a transfer.
module sio_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pha,
    input  logic              start_req,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              ev_lead,
    input  logic              ev_trail,
    input  logic              sdi_smp,
    output logic              busy,
    output logic              out_bit,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);

    logic [DATA_W-1:0] shreg;
    logic [EW-1:0]     edge_cnt;
    logic              start, ev, smp_ev, drv_ev, last;
    logic [DATA_W-1:0] shifted;

    assign start   = start_req && enable && !busy;
    assign ev      = ev_lead || ev_trail;
    assign smp_ev  = pha ? ev_lead : ev_trail;
    assign drv_ev  = pha ? ev_trail : ev_lead;
    assign last    = ev && (edge_cnt == EW'(EDGES - 1));
    assign shifted = {shreg[DATA_W-2:0], sdi_smp};

    // Transfer sequencing: load, shift per edge, finish on last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            edge_cnt <= '0;
            shreg    <= '0;
            out_bit  <= 1'b0;
            rx_byte  <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                busy     <= 1'b0;
                edge_cnt <= '0;
                out_bit  <= 1'b0;
            end else if (start) begin
                busy     <= 1'b1;
                edge_cnt <= '0;
                shreg    <= tx_byte;
                if (pha)
                    out_bit <= tx_byte[DATA_W-1];
            end else if (busy && ev) begin
                edge_cnt <= edge_cnt + 1'b1;
                if (smp_ev)
                    shreg <= shifted;
                if (drv_ev && !last)
                    out_bit <= shreg[DATA_W-1];
                if (last) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    rx_byte <= smp_ev ? shifted : shreg;
                end
            end
        end
    end

    // R9: the done pulse lasts a single cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a transfer only begins after a transmit write
    assert_start_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_req && enable));
endmodule

// File: rtl/sio_engine.sv
// Top of the serial transfer engine. Connects the control register,
// the edge source and the shift engine, and forms the pin outputs.
// Assumes the clock and data pins are wired to the outside through
// sck_o/sck_oe/sck_i, sdo and sdi.
module sio_engine
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              enable,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              sdo,
    input  logic              sdi
);
    localparam int DIV_W = (1 << SEL_W) - 2;

    sio_ctl_t ctl;
    logic     slave, ev_lead, ev_trail, sck_lvl, sdi_smp, busy, out_bit;

    assign slave  = ctl.sel == SEL_SLAVE;
    assign sck_o  = sck_lvl;
    assign sck_oe = enable && !slave;
    assign sdo    = enable && out_bit;

    sio_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .lock  (enable),
        .ctl_q (ctl)
    );

    sio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .slave    (slave),
        .pol      (ctl.pol),
        .sel      (ctl.sel),
        .sck_i    (sck_i),
        .sdi_i    (sdi),
        .ev_lead  (ev_lead),
        .ev_trail (ev_trail),
        .sck_lvl  (sck_lvl),
        .sdi_smp  (sdi_smp)
    );

    sio_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .pha       (ctl.pha),
        .start_req (tx_we),
        .tx_byte   (tx_data),
        .ev_lead   (ev_lead),
        .ev_trail  (ev_trail),
        .sdi_smp   (sdi_smp),
        .busy      (busy),
        .out_bit   (out_bit),
        .rx_byte   (rx_data),
        .done      (rx_done)
    );

    // R10: a disabled engine never reports completion
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rx_done);
    // R10: while disabled the master clock rests at the polarity level
    assert_disabled_rest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !slave) |=> (sck_o == ~$past(ctl.pol)));
endmodule

// File: tb/sio_engine_tb_top.sv
`timescale 1ns/1ps
module sio_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       enable = 1'b0;
    logic       tx_we = 1'b0;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic       rx_done;
    logic       sck_i = 1'b1;
    logic       sck_o, sck_oe, sdo;
    logic       sdi = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_rx[$];
    logic [7:0] exp_peer[$];

    // peer device model for master-mode transfers
    logic       pm_pol = 1'b0, pm_pha = 1'b0, pm_act = 1'b0, prev_sck = 1'b1;
    logic [7:0] pm_tx = '0, pm_rx = '0;
    int         pm_idx = 0, pm_nsmp = 0;

    always #4 clk = ~clk;

    sio_engine dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .enable(enable), .tx_we(tx_we), .tx_data(tx_data), .rx_data(rx_data),
        .rx_done(rx_done), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdo(sdo), .sdi(sdi)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    // monitor: compare every done pulse against the scoreboard (R9, R6)
    always @(negedge clk) begin
        if (rst_n && rx_done) begin
            if (exp_rx.size() == 0)
                check(1'b0, "R8 unexpected rx_done", rx_data, 0);
            else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                check(rx_data == e, "R9 rx_data", rx_data, e);
            end
        end
    end

    // peer: reacts to sck_o after each rising edge of clk (R5)
    initial begin
        forever begin
            @(posedge clk); #2;
            if (pm_act && sck_o != prev_sck) begin
                logic lead;
                lead = (prev_sck == ~pm_pol);
                if (lead != pm_pha) begin
                    if (pm_idx >= 0) begin sdi = pm_tx[pm_idx]; pm_idx--; end
                end else begin
                    pm_rx = {pm_rx[6:0], sdo};
                    pm_nsmp++;
                    if (pm_nsmp == 8) begin
                        logic [7:0] e;
                        pm_act = 1'b0;
                        e = (exp_peer.size() != 0) ? exp_peer.pop_front() : 8'h00;
                        check(pm_rx == e, "R5 peer received byte", pm_rx, e);
                    end
                end
            end
            prev_sck = sck_o;
        end
    end

    // driver: queue expectations and issue one transmit write (call at negedge)
    task automatic start_xfer(input logic [7:0] tx, input logic [7:0] pb);
        exp_rx.push_back(pb);
        exp_peer.push_back(tx);
        pm_tx = pb; pm_rx = '0; pm_nsmp = 0;
        if (pm_pha) begin sdi = pb[7]; pm_idx = 6; end
        else pm_idx = 7;
        pm_act = 1'b1;
        tx_we = 1'b1; tx_data = tx;
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    task automatic wait_done(output int cnt);
        cnt = 0;
        while (!rx_done && cnt < 5000) begin @(negedge clk); cnt++; end
    endtask

    task automatic timed_xfer(input logic [7:0] tx, input logic [7:0] pb, input int code);
        int c;
        start_xfer(tx, pb);
        wait_done(c);
        check(c == (16 << code), "R2 done latency", c, 16 << code);
    endtask

    task automatic setup(input logic pol, input logic pha, input logic [2:0] code);
        @(negedge clk); enable = 1'b0;
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = {3'b000, pol, pha, code};
        @(negedge clk); ctl_we = 1'b0; pm_pol = pol; pm_pha = pha;
        sck_i = ~pol; enable = 1'b1;
        @(negedge clk);
        check(sck_oe == (code != 3'b111), "R3 sck_oe", sck_oe, code != 3'b111);
        if (code != 3'b111)
            check(sck_o == ~pol, "R4 rest level", sck_o, ~pol);
    endtask

    // bench acts as master toward a slave-mode engine, half period of 6 cycles
    task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] mb, input logic pol, input logic pha);
        logic [7:0] got;
        got = '0;
        exp_rx.push_back(mb);
        tx_we = 1'b1; tx_data = tx;
        @(negedge clk); tx_we = 1'b0;
        if (pha) sdi = mb[7];
        repeat (6) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            if (pha) got = {got[6:0], sdo};
            sck_i = pol;
            if (!pha) sdi = mb[i];
            if (i == 7 && !pha) begin
                repeat (2) @(negedge clk);
                check(sdo == 1'b0, "R11 sdo not before third edge", sdo, 0);
                @(negedge clk);
                check(sdo == tx[7], "R11 sdo on third edge", sdo, tx[7]);
                repeat (3) @(negedge clk);
            end else
                repeat (6) @(negedge clk);
            if (!pha) got = {got[6:0], sdo};
            sck_i = ~pol;
            if (pha && i > 0) sdi = mb[i-1];
            repeat (6) @(negedge clk);
        end
        check(got == tx, "R3 slave-mode byte seen by master", got, tx);
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R10: reset state
        check(rx_done == 1'b0, "R1 rx_done after reset", rx_done, 0);
        check(sdo == 1'b0, "R1 sdo after reset", sdo, 0);
        check(sck_o == 1'b1, "R1 sck_o rests high", sck_o, 1);
        check(sck_oe == 1'b0, "R1 sck_oe after reset", sck_oe, 0);
        // R1: default control gives type 1, divide by 2
        enable = 1'b1;
        @(negedge clk);
        check(sck_oe == 1'b1, "R3 master drives clock", sck_oe, 1);
        timed_xfer(8'hA5, 8'h3C, 0);
        @(negedge clk);
        check(rx_done == 1'b0, "R9 done one cycle", rx_done, 0);
        // R5, R2: other timing types and dividers
        setup(1'b0, 1'b1, 3'd1); timed_xfer(8'h81, 8'h7E, 1);
        setup(1'b1, 1'b0, 3'd2); timed_xfer(8'h5A, 8'hC3, 2);
        setup(1'b1, 1'b1, 3'd3); timed_xfer(8'h01, 8'h80, 3);
        // R7: control write while enabled is ignored
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h00;
        @(negedge clk); ctl_we = 1'b0;
        check(sck_o == 1'b0, "R7 rest level kept", sck_o, 0);
        timed_xfer(8'hF0, 8'h0F, 3);
        // R2: largest divider
        setup(1'b0, 1'b0, 3'd6); timed_xfer(8'h96, 8'h69, 6);
        // R8: write during a transfer is ignored
        setup(1'b0, 1'b0, 3'd2);
        start_xfer(8'h6B, 8'hD4);
        repeat (20) @(negedge clk);
        tx_we = 1'b1; tx_data = 8'hFF;
        @(negedge clk); tx_we = 1'b0;
        wait_done(c);
        check(c == 64 - 21, "R8 busy write ignored, timing", c, 64 - 21);
        // R8, R10: write while disabled is ignored, outputs quiet
        @(negedge clk); enable = 1'b0;
        @(negedge clk); tx_we = 1'b1; tx_data = 8'hFF;
        @(negedge clk); tx_we = 1'b0;
        repeat (40) @(negedge clk);
        check(sdo == 1'b0, "R10 sdo low when disabled", sdo, 0);
        check(sck_o == 1'b1, "R10 sck_o at rest when disabled", sck_o, 1);
        // R12: back-to-back transfer started in the done cycle
        setup(1'b0, 1'b0, 3'd1);
        start_xfer(8'h3A, 8'hB2);
        wait_done(c);
        timed_xfer(8'hC5, 8'h4D, 1);
        // R3, R11: slave mode in two timing types
        setup(1'b0, 1'b0, 3'd7);
        slave_xfer(8'hB7, 8'h2E, 1'b0, 1'b0);
        repeat (8) @(negedge clk);
        setup(1'b1, 1'b1, 3'd7);
        slave_xfer(8'h4C, 8'hE1, 1'b1, 1'b1);
        repeat (8) @(negedge clk);
        check(exp_rx.size() == 0, "R9 all transfers completed", exp_rx.size(), 0);
        check(exp_peer.size() == 0, "R5 all peer bytes seen", exp_peer.size(), 0);
        summary();
        $finish;
    end
endmodule